// File: doc/BRIEF.md
# Scanline Memory Fetch Scheduler

This block decides, for every master cycle of a video scanline, whether the picture generator reaches out to its external video memory, and what that access is for. The line timing generator supplies the current cycle position within the line (0 to 1363) and a flag that marks lines on which fetching takes place (visible lines and the pre-render line). Two enables, one for background and one for sprites, gate the whole schedule. When either enable is set, one access is issued per 8-cycle slot, 170 slots in all. The 4 cycles after the last slot are a quiet tail.

Each access carries a kind code and an index. The index is a background tile number or a sprite number, and downstream address logic uses it to build the memory address. The first 128 slots fetch background tiles 2 to 33. These are the third and later tiles drawn on the line, because tiles 0 and 1 were prefetched near the end of the previous line. The next 32 slots alternate two throw-away name reads with the two pattern bytes of one sprite, for sprites 0 to 7. The next 8 slots prefetch tiles 0 and 1 for the following line. The last two slots re-read the name byte of tile 2.

All outputs are registered. They reflect the cycle position and enables that were presented at the previous clock edge.

Top module: `fetch_sched`

## Requirements
- R1: `fetch_strobe` is high for exactly one cycle per active slot. That cycle is offset 1 of the slot (position mod 8 == 1). A slot is active when its position is below 1360, `line_active` is high, and at least one enable is high.
- R2: Slots 0 to 127 (slot = position / 8) use kind 1 (name), 2 (attribute), 3 (background pattern low) and 4 (background pattern high), chosen by slot mod 4. The index is 2 + slot / 4.
- R3: Slots 128 to 159 use kind 5 (throw-away name) when (slot-128) mod 4 is 0 or 1. They use kind 6 (sprite pattern low) when it is 2, and kind 7 (sprite pattern high) when it is 3. The index is (slot-128) / 4. These sprite fetches occur whenever fetching is enabled, including when `spr_enable` is low.
- R4: Slots 160 to 167 follow the same kind sequence as R2. The index is (slot-160) / 4, giving tiles 0 and 1.
- R5: Slots 168 and 169 both use kind 1 (name) with index 2, which is the same tile as slot 0.
- R6: For positions 1360 to 1363, the kind is 0 (none), the index is 0, and both strobes are low.
- R7: When `bg_enable` and `spr_enable` are both low, the kind is 0, the index is 0, and both strobes are low.
- R8: When `line_active` is low, the kind is 0, the index is 0, and both strobes are low.
- R9: Within an active slot presented on consecutive positions, the kind and index stay constant across all 8 cycles.
- R10: `fetch_read` is high on offsets 2 to 7 of an active slot and is never high together with `fetch_strobe`.
- R11: While `rst_n` is low at a clock edge, all outputs become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_pos | input | 11 | Cycle position within the scanline, 0 to 1363 |
| line_active | input | 1 | High on lines where fetching is scheduled |
| bg_enable | input | 1 | Background rendering enable |
| spr_enable | input | 1 | Sprite rendering enable |
| fetch_strobe | output | 1 | Address-valid strobe, offset 1 of a slot |
| fetch_read | output | 1 | Read strobe, offsets 2 to 7 of a slot |
| fetch_kind | output | 3 | Access kind code: 0 none, 1 to 7 per R2 and R3 |
| fetch_index | output | 6 | Tile or sprite number for the access |

## Verification
The assertions assume that `line_pos` stays below 1364. The read-follows-strobe property also assumes that the position advances by one per clock while the enables and `line_active` are held steady. The bench honours both assumptions. It sweeps whole lines in order, and it changes the enables and `line_active` only at line boundaries. A final segment visits scattered positions, and for that segment the bench drops the ordering assumption on purpose. The scoreboard predicts each registered output one cycle after its stimulus, so disabled lines and the tail are checked through the ports.

// File: rtl/fetch_sched_pkg.sv
// Shared kind codes for the scanline fetch scheduler.
// Assumes: a 3-bit code is carried on the top-level ports as plain logic.
package fetch_sched_pkg;
    typedef enum logic [2:0] {
        FK_NONE    = 3'd0,
        FK_NAME    = 3'd1,
        FK_ATTR    = 3'd2,
        FK_BG_LO   = 3'd3,
        FK_BG_HI   = 3'd4,
        FK_GARBAGE = 3'd5,
        FK_SPR_LO  = 3'd6,
        FK_SPR_HI  = 3'd7
    } fetch_kind_e;
endpackage

// File: rtl/fetch_slot_split.sv
// Splits a line position into slot number and offset within the slot.
// Assumes: SLOT_CYCLES is a power of two.
module fetch_slot_split #(
    parameter int CYC_W       = 11,
    parameter int SLOT_CYCLES = 8,
    parameter int SLOTS       = 170,
    parameter int SLOT_W      = 8
) (
    input  logic [CYC_W-1:0]             line_pos,
    output logic [SLOT_W-1:0]            slot_num,
    output logic [$clog2(SLOT_CYCLES)-1:0] slot_off,
    output logic                         in_slots
);
    localparam int OFF_W    = $clog2(SLOT_CYCLES);
    localparam int SLOT_END = SLOTS * SLOT_CYCLES;

    // Position decomposition into slot and offset
    always_comb begin
        slot_num = SLOT_W'(line_pos >> OFF_W);
        slot_off = line_pos[OFF_W-1:0];
        in_slots = (int'(line_pos) < SLOT_END);
    end
endmodule

// File: rtl/fetch_phase_decode.sv
// Maps a slot number onto an access kind and tile or sprite index.
// Assumes: the caller only uses the result when the slot is below SLOTS.
module fetch_phase_decode
    import fetch_sched_pkg::*;
#(
    parameter int SLOT_W         = 8,
    parameter int IDX_W          = 6,
    parameter int BG_TILES       = 32,
    parameter int SPR_COUNT      = 8,
    parameter int PREFETCH_TILES = 2,
    parameter int EXTRA_NAMES    = 2
) (
    input  logic [SLOT_W-1:0] slot_num,
    output fetch_kind_e       kind,
    output logic [IDX_W-1:0]  index
);
    localparam int GROUP   = 4;
    localparam int BG_END  = BG_TILES * GROUP;
    localparam int SPR_END = BG_END + SPR_COUNT * GROUP;
    localparam int PRE_END = SPR_END + PREFETCH_TILES * GROUP;
    localparam int ALL_END = PRE_END + EXTRA_NAMES;

    logic [SLOT_W-1:0] rel;

    // Background four-fetch kind by phase within a group
    function automatic fetch_kind_e bg_kind(input logic [1:0] ph);
        case (ph)
            2'd0:    return FK_NAME;
            2'd1:    return FK_ATTR;
            2'd2:    return FK_BG_LO;
            default: return FK_BG_HI;
        endcase
    endfunction

    // Region selection and index arithmetic
    always_comb begin
        kind  = FK_NONE;
        index = '0;
        rel   = '0;
        if (int'(slot_num) < BG_END) begin
            rel   = slot_num;
            kind  = bg_kind(rel[1:0]);
            index = IDX_W'(PREFETCH_TILES) + IDX_W'(rel >> 2);
        end else if (int'(slot_num) < SPR_END) begin
            rel   = slot_num - SLOT_W'(BG_END);
            kind  = !rel[1] ? FK_GARBAGE : (rel[0] ? FK_SPR_HI : FK_SPR_LO);
            index = IDX_W'(rel >> 2);
        end else if (int'(slot_num) < PRE_END) begin
            rel   = slot_num - SLOT_W'(SPR_END);
            kind  = bg_kind(rel[1:0]);
            index = IDX_W'(rel >> 2);
        end else if (int'(slot_num) < ALL_END) begin
            kind  = FK_NAME;
            index = IDX_W'(PREFETCH_TILES);
        end
    end
endmodule

// File: rtl/fetch_strobe_gen.sv
// Produces address-valid and read strobes from the offset within a slot.
// Assumes: go is already gated by line, enable and slot range.
module fetch_strobe_gen #(
    parameter int OFF_W      = 3,
    parameter int STROBE_OFF = 1
) (
    input  logic [OFF_W-1:0] slot_off,
    input  logic             go,
    output logic             ale,
    output logic             rd
);
    // Single-cycle address strobe, read over the rest of the slot
    always_comb begin
        ale = go && (int'(slot_off) == STROBE_OFF);
        rd  = go && (int'(slot_off) >  STROBE_OFF);
    end
endmodule

// File: rtl/fetch_sched.sv
// Scanline fetch scheduler top: one external access per slot, tagged with
// kind and index, outputs registered one cycle after the position input.
// Assumes: line_pos counts 0..LINE_CYCLES-1 from the line timing generator.
module fetch_sched
    import fetch_sched_pkg::*;
#(
    parameter int CYC_W          = 11,
    parameter int SLOT_CYCLES    = 8,
    parameter int BG_TILES       = 32,
    parameter int SPR_COUNT      = 8,
    parameter int PREFETCH_TILES = 2,
    parameter int EXTRA_NAMES    = 2,
    parameter int IDX_W          = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CYC_W-1:0] line_pos,
    input  logic             line_active,
    input  logic             bg_enable,
    input  logic             spr_enable,
    output logic             fetch_strobe,
    output logic             fetch_read,
    output logic [2:0]       fetch_kind,
    output logic [IDX_W-1:0] fetch_index
);
    localparam int OFF_W  = $clog2(SLOT_CYCLES);
    localparam int SLOTS  = (BG_TILES + SPR_COUNT + PREFETCH_TILES) * 4 + EXTRA_NAMES;
    localparam int SLOT_W = $clog2(SLOTS);

    logic [SLOT_W-1:0] slot_num;
    logic [OFF_W-1:0]  slot_off;
    logic              in_slots;
    logic              go;
    logic              ale_c, rd_c;
    fetch_kind_e       kind_c;
    logic [IDX_W-1:0]  index_c;

    fetch_slot_split #(
        .CYC_W(CYC_W), .SLOT_CYCLES(SLOT_CYCLES), .SLOTS(SLOTS), .SLOT_W(SLOT_W)
    ) u_split (
        .line_pos(line_pos), .slot_num(slot_num), .slot_off(slot_off), .in_slots(in_slots)
    );

    fetch_phase_decode #(
        .SLOT_W(SLOT_W), .IDX_W(IDX_W), .BG_TILES(BG_TILES), .SPR_COUNT(SPR_COUNT),
        .PREFETCH_TILES(PREFETCH_TILES), .EXTRA_NAMES(EXTRA_NAMES)
    ) u_decode (
        .slot_num(slot_num), .kind(kind_c), .index(index_c)
    );

    fetch_strobe_gen #(.OFF_W(OFF_W), .STROBE_OFF(1)) u_strobe (
        .slot_off(slot_off), .go(go), .ale(ale_c), .rd(rd_c)
    );

    // Fetching allowed on scheduled lines, with an enable, inside the slots
    always_comb go = line_active && (bg_enable || spr_enable) && in_slots;

    // Output registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_strobe <= 1'b0;
            fetch_read   <= 1'b0;
            fetch_kind   <= FK_NONE;
            fetch_index  <= '0;
        end else begin
            fetch_strobe <= ale_c;
            fetch_read   <= rd_c;
            fetch_kind   <= go ? kind_c : FK_NONE;
            fetch_index  <= go ? index_c : '0;
        end
    end
endmodule

// File: rtl/fetch_sched_checker.sv
// Protocol checker for fetch_sched, bound to every instance.
// Assumes: line_pos below SLOT_END+tail and steady enables within a line.
module fetch_sched_checker #(
    parameter int CYC_W     = 11,
    parameter int IDX_W     = 6,
    parameter int SLOT_END  = 1360,
    parameter int SPR_COUNT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CYC_W-1:0] line_pos,
    input logic             line_active,
    input logic             bg_enable,
    input logic             spr_enable,
    input logic             fetch_strobe,
    input logic             fetch_read,
    input logic [2:0]       fetch_kind,
    input logic [IDX_W-1:0] fetch_index
);
    AST_STROBE_HAS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_strobe |-> fetch_kind != 3'd0); // R1
    AST_SPRITE_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_kind >= 3'd6) |-> (int'(fetch_index) < SPR_COUNT)); // R3
    AST_TAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(line_pos) >= SLOT_END) |=> (fetch_kind == 3'd0 && !fetch_strobe && !fetch_read)); // R6
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!bg_enable && !spr_enable) |=> (fetch_kind == 3'd0 && !fetch_strobe && !fetch_read)); // R7
    AST_LINE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !line_active |=> (fetch_kind == 3'd0 && fetch_index == '0 && !fetch_read)); // R8
    AST_STROBE_READ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_strobe && fetch_read)); // R10
    AST_READ_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_strobe && line_pos[2:0] == 3'd2 && line_active && (bg_enable || spr_enable))
        |=> fetch_read); // R10
endmodule

bind fetch_sched fetch_sched_checker #(
    .CYC_W(CYC_W), .IDX_W(IDX_W), .SLOT_END(SLOTS * SLOT_CYCLES), .SPR_COUNT(SPR_COUNT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .line_pos(line_pos), .line_active(line_active),
    .bg_enable(bg_enable), .spr_enable(spr_enable), .fetch_strobe(fetch_strobe),
    .fetch_read(fetch_read), .fetch_kind(fetch_kind), .fetch_index(fetch_index)
);

// File: tb/fetch_sched_tb.sv
// Scoreboard bench: the driver pushes predicted outputs, the monitor pops
// and compares them one clock later.
module fetch_sched_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] line_pos = '0;
    logic        line_active = 1'b0, bg_enable = 1'b0, spr_enable = 1'b0;
    logic        fetch_strobe, fetch_read;
    logic [2:0]  fetch_kind;
    logic [5:0]  fetch_index;

    typedef struct {
        int    pos;
        bit    act;
        bit    ale;
        bit    rd;
        int    kind;
        int    idx;
        string req;
    } exp_t;

    exp_t q[$];
    int checks = 0, failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fetch_sched u_dut (
        .clk(clk), .rst_n(rst_n), .line_pos(line_pos), .line_active(line_active),
        .bg_enable(bg_enable), .spr_enable(spr_enable), .fetch_strobe(fetch_strobe),
        .fetch_read(fetch_read), .fetch_kind(fetch_kind), .fetch_index(fetch_index)
    );

    // Reference model written from the requirement text
    function automatic exp_t predict(int c, bit la, bit bg, bit sp);
        exp_t e;
        int s, o;
        e.pos = c; e.act = 0; e.ale = 0; e.rd = 0; e.kind = 0; e.idx = 0;
        s = c / 8; o = c % 8;
        if (!la)           begin e.req = "R8"; return e; end
        if (!bg && !sp)    begin e.req = "R7"; return e; end
        if (c >= 1360)     begin e.req = "R6"; return e; end
        e.act = 1; e.ale = (o == 1); e.rd = (o >= 2);
        if (s < 128) begin
            e.kind = 1 + s % 4; e.idx = 2 + s / 4; e.req = "R2";
        end else if (s < 160) begin
            e.kind = ((s - 128) % 4 < 2) ? 5 : 6 + (s - 128) % 2;
            e.idx = (s - 128) / 4; e.req = "R3";
        end else if (s < 168) begin
            e.kind = 1 + (s - 160) % 4; e.idx = (s - 160) / 4; e.req = "R4";
        end else begin
            e.kind = 1; e.idx = 2; e.req = "R5";
        end
        return e;
    endfunction

    // Driver: apply one position and queue its prediction
    task automatic drive(int c, bit la, bit bg, bit sp);
        @(negedge clk);
        line_pos = 11'(c); line_active = la; bg_enable = bg; spr_enable = sp;
        q.push_back(predict(c, la, bg, sp));
    endtask

    task automatic sweep_line(bit la, bit bg, bit sp);
        for (int c = 0; c < 1364; c++) drive(c, la, bg, sp);
    endtask

    // Monitor: compare outputs against queued predictions after each edge
    initial begin
        exp_t prev;
        bit have_prev = 0;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (fetch_strobe !== e.ale || fetch_read !== e.rd) begin
                    failures++;
                    $display("FAIL R1 R10 pos=%0d strobe/read actual=%b/%b expected=%b/%b",
                             e.pos, fetch_strobe, fetch_read, e.ale, e.rd);
                end
                checks++;
                if (int'(fetch_kind) != e.kind || int'(fetch_index) != e.idx) begin
                    failures++;
                    $display("FAIL %s pos=%0d kind/index actual=%0d/%0d expected=%0d/%0d",
                             e.req, e.pos, fetch_kind, fetch_index, e.kind, e.idx);
                end
                if (have_prev && prev.act && e.act && e.pos == prev.pos + 1 && e.pos % 8 != 0) begin
                    checks++; // R9 stability within a slot
                    if (int'(fetch_kind) != prev.kind || int'(fetch_index) != prev.idx) begin
                        failures++;
                        $display("FAIL R9 pos=%0d kind/index actual=%0d/%0d expected=%0d/%0d",
                                 e.pos, fetch_kind, fetch_index, prev.kind, prev.idx);
                    end
                end
                prev = e; have_prev = 1;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Stimulus sequence
    initial begin
        // R11: reset holds outputs at zero even with an active slot presented
        line_pos = 11'd1; line_active = 1; bg_enable = 1; spr_enable = 1;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (fetch_strobe !== 0 || fetch_read !== 0 || fetch_kind !== 0 || fetch_index !== 0) begin
            failures++;
            $display("FAIL R11 reset outputs actual=%b%b/%0d/%0d expected=00/0/0",
                     fetch_strobe, fetch_read, fetch_kind, fetch_index);
        end
        @(negedge clk); rst_n = 1;

        sweep_line(1, 1, 1);   // R2 R3 R4 R5 R6 full schedule
        sweep_line(1, 1, 0);   // R3 sprite fetches with sprites disabled
        sweep_line(1, 0, 1);   // sprites only
        sweep_line(1, 0, 0);   // R7 both disabled
        sweep_line(0, 1, 1);   // R8 line not scheduled
        sweep_line(1, 1, 1);   // resume after idle lines
        for (int k = 0; k < 400; k++) drive((k * 331 + 7) % 1364, 1, 1, 1);
        drive(1359, 1, 1, 1); drive(1360, 1, 1, 1); drive(1363, 1, 1, 1);
        drive(0, 1, 1, 1);

        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule